// File: doc/BRIEF.md
# Edge-Latching Secondary Interrupt Controller

This block collects interrupt events from a parameterised set of sources and presents them to a parent controller through one interrupt line. Each source passes through a synchroniser; a low-to-high transition then sets that source's bit in a pending-event register. The bit stays set until software clears it. A separate enable register selects which pending bits reach the output line. A priority encoder reports the highest-numbered pending and enabled source, which software services first.

Pending bits latch whether or not the source is enabled. Software therefore clears a stale event before it enables the source, because enabling a source never clears its pending bit. A bit is cleared by writing 0 to it. Writing 1 leaves it alone, so one write can acknowledge a chosen subset of events without a read-modify-write race. If a new edge and a clear of the same bit fall in the same cycle, the new edge wins.

Top module: `edge_irq_bridge`

## Requirements
- R1: After reset, the pending register (offset 0x00) and the enable register (offset 0x04) both read 0, `irq_o` is low and `pend_valid_o` is low.
- R2: A low-to-high transition on `src_i[k]`, held for at least two clock cycles, sets pending bit k by the third rising clock edge after the transition. A source that stays high produces only one event.
- R3: A pending bit is set by an edge even when its enable bit is 0, and `irq_o` stays low while no enabled bit is pending.
- R4: A write to offset 0x00 clears every pending bit whose write-data bit is 0 and leaves every bit whose write-data bit is 1 unchanged.
- R5: The enable register at offset 0x04 reads back the value written (bit k = 1 enables source k), and `irq_o` is high exactly when some bit is set in both pending and enable.
- R6: Setting an enable bit does not clear the matching pending bit. A stale pending bit asserts `irq_o` as soon as it is enabled.
- R7: `pend_valid_o` is high when any pending-and-enabled bit exists, and `pend_idx_o` then gives the highest index k with both bits set.
- R8: When an edge on source k is detected in the same cycle as a write to offset 0x00 that writes 0 to bit k, bit k ends up set.
- R9: Bits at positions `NUM_SRC` and above in both registers read 0 and ignore writes. Any address other than 0x00 and 0x04 reads 0.
- R10: A high-to-low transition on a source does not set its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source levels |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt line to the parent controller |
| pend_valid_o | output | 1 | A pending, enabled source exists |
| pend_idx_o | output | IDX_W | Highest pending, enabled source index |

## Verification
The assertions assume three things about the inputs. Each source level is stable for at least two cycles, so the synchroniser sees every transition. Write data matters only in the cycle the strobe is high. Reset is applied before the first write. The bench holds every source pulse high for two cycles and low for at least three. It raises the write strobe for exactly one cycle at a time and leaves the write-data bus settled across that cycle. The case where an edge meets a clear is driven by timing the write strobe to land on the edge-detect cycle, which is the third clock after the source rises.

// File: rtl/eib_pkg.sv
package eib_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h04;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/eib_edge_detect.sv
module eib_edge_detect #(
    parameter int NUM_SRC = 32,
    parameter int STAGES  = eib_pkg::SYNC_STAGES
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] rise_o
);
    logic [STAGES-1:0][NUM_SRC-1:0] stage_q;
    logic [NUM_SRC-1:0]             last_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[s] <= '0;
                    else         stage_q[s] <= src_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[s] <= '0;
                    else         stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= '0;
        else         last_q <= stage_q[STAGES-1];
    end

    assign rise_o = stage_q[STAGES-1] & ~last_q;

    // R2: a detected rise lasts one cycle only, so a held level yields one event
    assert_single_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/eib_regs.sv
module eib_regs
    import eib_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic               wr_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [DATA_W-1:0]  rdata_o
);
    logic [NUM_SRC-1:0] pend_q, enable_q, pend_d;
    logic               pend_wr, enable_wr;

    assign pend_wr   = wr_i && (addr_i == OFS_PEND);
    assign enable_wr = wr_i && (addr_i == OFS_ENABLE);

    always_comb begin
        pend_d = pend_q;
        if (pend_wr) pend_d = pend_d & wdata_i;
        pend_d = pend_d | rise_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q   <= '0;
            enable_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (enable_wr) enable_q <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_PEND)        rdata_o[NUM_SRC-1:0] = pend_q;
        else if (addr_i == OFS_ENABLE) rdata_o[NUM_SRC-1:0] = enable_q;
    end

    assign pend_o   = pend_q;
    assign enable_o = enable_q;

    // R8: no detected edge is ever lost, even against a clearing write
    assert_no_lost_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (~pend_q & $past(rise_i)) == '0);
    // R4: after a clearing write only kept bits or fresh edges remain
    assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(pend_wr) |-> ((pend_q & ~($past(pend_q & wdata_i) | $past(rise_i))) == '0));
    // R2: a pending bit rises only after an edge
    assert_set_by_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q & ~$past(pend_q) & ~$past(rise_i)) == '0);
    // R6: an enable write never clears pending state
    assert_enable_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(enable_wr) |-> ((~pend_q & $past(pend_q)) == '0));
endmodule

// File: rtl/eib_prio.sv
module eib_prio #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
    assign valid_o = |req_i;
endmodule

// File: rtl/edge_irq_bridge.sv
module edge_irq_bridge
    import eib_pkg::*;
#(
    parameter int  NUM_SRC = 32,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    input  logic               bus_wr_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic               pend_valid_o,
    output logic [IDX_W-1:0]   pend_idx_o
);
    logic [NUM_SRC-1:0] rise, pend, enable, active;

    generate
        if (NUM_SRC < DATA_W) begin : g_hi
            logic unused_hi_bits;
            assign unused_hi_bits = ^bus_wdata_i[DATA_W-1:NUM_SRC];
        end
    endgenerate

    eib_edge_detect #(.NUM_SRC(NUM_SRC)) edge_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .src_i (src_i),
        .rise_o(rise)
    );

    eib_regs #(.NUM_SRC(NUM_SRC)) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rise_i  (rise),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i[NUM_SRC-1:0]),
        .wr_i    (bus_wr_i),
        .pend_o  (pend),
        .enable_o(enable),
        .rdata_o (bus_rdata_o)
    );

    assign active = pend & enable;

    eib_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) prio_i (
        .req_i  (active),
        .valid_o(pend_valid_o),
        .idx_o  (pend_idx_o)
    );

    assign irq_o = |active;

    // R7: the reported index is pending, enabled and has no higher active bit
    assert_top_index_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_valid_o |-> ((active >> pend_idx_o) == {{(NUM_SRC-1){1'b0}}, 1'b1}));
    // R5: the line and the encoder agree
    assert_line_matches_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == pend_valid_o);
endmodule

// File: tb/edge_irq_bridge_tb.sv
`timescale 1ns/100ps
module edge_irq_bridge_tb_top;
    localparam int NSRC = 20;
    localparam int IW   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic [7:0]        addr = 8'h00;
    logic [31:0]       wdata = '0;
    logic              wr = 1'b0;
    logic [31:0]       rdata;
    logic              irq, pvalid;
    logic [IW-1:0]     pidx;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    edge_irq_bridge #(.NUM_SRC(NSRC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_wr_i(wr),
        .bus_rdata_o(rdata), .irq_o(irq), .pend_valid_o(pvalid), .pend_idx_o(pidx)
    );

    // monitor: kind 0 = read data, 1 = irq, 2 = valid, 3 = index
    always @(negedge clk) begin
        #1;
        while (kind_q.size() > 0) begin
            int k;
            logic [31:0] e, a;
            string t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            case (k)
                0: a = rdata;
                1: a = {31'b0, irq};
                2: a = {31'b0, pvalid};
                default: a = {{(32-IW){1'b0}}, pidx};
            endcase
            n_vec++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic chk_reg(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a;
        kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
    endtask

    task automatic chk_out(input int k, input logic [31:0] e, input string t);
        @(negedge clk);
        kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        src[i] = 1'b1;
        repeat (2) @(negedge clk);
        src[i] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_reg(8'h00, 32'h0, "R1 pending reset");
        chk_reg(8'h04, 32'h0, "R1 enable reset");
        chk_out(1, 32'h0, "R1 irq reset");
        chk_out(2, 32'h0, "R1 valid reset");

        pulse(3);
        chk_reg(8'h00, 32'h8, "R2 R3 masked edge latches");
        chk_out(1, 32'h0, "R3 irq low while masked");

        @(negedge clk); src[5] = 1'b1;
        repeat (4) @(negedge clk);
        chk_reg(8'h00, 32'h28, "R2 held source latches");
        wr_reg(8'h00, ~(32'h1 << 5));
        chk_reg(8'h00, 32'h8, "R4 zero clears bit 5");
        repeat (4) @(negedge clk);
        chk_reg(8'h00, 32'h8, "R2 held level single event");
        @(negedge clk); src[5] = 1'b0;
        repeat (4) @(negedge clk);
        chk_reg(8'h00, 32'h8, "R10 falling edge ignored");

        wr_reg(8'h00, 32'hFFFF_FFFF);
        chk_reg(8'h00, 32'h8, "R4 ones keep state");

        wr_reg(8'h04, 32'h8);
        chk_reg(8'h04, 32'h8, "R5 enable readback");
        chk_out(1, 32'h1, "R5 R6 stale event drives irq");
        chk_reg(8'h00, 32'h8, "R6 enable keeps pending");
        chk_out(3, 32'd3, "R7 index 3");

        pulse(12);
        pulse(7);
        wr_reg(8'h04, 32'h88);
        chk_reg(8'h00, 32'h1088, "R2 two more events");
        chk_out(3, 32'd7, "R7 masked 12 skipped");
        wr_reg(8'h04, 32'h1088);
        chk_out(3, 32'd12, "R7 highest index 12");
        chk_out(2, 32'h1, "R7 valid");
        wr_reg(8'h00, ~(32'h1 << 12));
        chk_out(3, 32'd7, "R7 after clearing 12");
        wr_reg(8'h00, 32'h0);
        chk_out(1, 32'h0, "R5 irq low after full clear");
        chk_out(2, 32'h0, "R7 valid low after full clear");

        // R8: edge detect lands on the third clock after the rise
        @(negedge clk); src[9] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 8'h00; wdata = 32'h0; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        @(negedge clk); src[9] = 1'b0;
        chk_reg(8'h00, 32'h200, "R8 edge beats clear");

        wr_reg(8'h04, 32'hFFFF_FFFF);
        chk_reg(8'h04, 32'h000F_FFFF, "R9 enable upper bits zero");
        chk_reg(8'h08, 32'h0, "R9 other address reads zero");
        chk_out(3, 32'd9, "R7 index 9");
        wr_reg(8'h00, 32'h0);
        chk_reg(8'h00, 32'h0, "R9 R4 pending cleared");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule